// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block sits between a set of per-operation-class ready queues and the issue-to-execute register of an out-of-order core. Every cycle each class offers the oldest instruction waiting in its queue: a valid bit, an unsigned sequence number (smaller means older, with no wrap handling) and a squashed flag. The class identity is given by the lane index. A per-class availability bit tells whether that class's functional unit can accept work this cycle. The selector decides which heads leave their queues, which units are claimed, and what lands in the issue slots on the next clock edge.

The selection ranks classes by the age of their heads, oldest first. Squashed heads are thrown away and use no issue bandwidth. A class whose unit is busy is stepped over, so a younger class can still issue. Classes are fixed by parameters. A class either needs a functional unit or does not. Its operations are either single-cycle or multi-cycle, and multi-cycle classes carry a completion delay. Multi-cycle operations are tracked by a per-class countdown. When that countdown finishes, the result is handed to the issue register. These completions take slots ahead of new issues. A saturation-free, wrapping busy counter per class records how often a class was reached while it could not issue.

The default configuration has four classes and two issue slots. Class 0 is single-cycle and needs a unit. Class 1 is single-cycle and needs no unit. Class 2 is multi-cycle with a delay of 3 and holds its unit until it completes. Class 3 is multi-cycle with a delay of 1 and uses a pipelined unit.

Top module: `iss_oldest_sel`

## Requirements
- R1: Eligible heads are granted in ascending sequence-number order. When two sequence numbers are equal, the lower class index wins. A head is eligible when it is valid, not squashed, has no completion pending in its class, and either has its unit available or belongs to a class that needs no unit.
- R2: Issues in a cycle never exceed the budget. The budget is W minus the number of multi-cycle completions delivered in that same cycle, and each grant of either kind uses one unit of it.
- R3: A valid squashed head is popped in the same cycle. It is never granted, claims no unit and uses no budget.
- R4: A valid, unsquashed head that is not eligible is skipped, and younger eligible heads may still be granted. Its class busy counter increases by one, wrapping at 2^CNT_W, only if fewer eligible heads are older than it than the budget allows. A granted head asserts its unit-claim strobe only if its unit was available.
- R5: A class that needs no unit issues whenever it is reached within the budget, whatever its availability bit says, and never asserts its claim strobe.
- R6: A single-cycle grant shows in an issue slot on the next cycle, carrying its sequence number and class index. A class that uses a unit pulses its release strobe on that same next cycle.
- R7: A multi-cycle grant loads a countdown with the class delay D. The result is ready D cycles after the grant and appears in a slot on the cycle after delivery. If no slot is free, it waits. The release strobe pulses the cycle after delivery when D > 1, and the cycle after the grant when D = 1.
- R8: A class grants at most one instruction per cycle. While it has a completion pending, it is not eligible.
- R9: The issued-count output equals the number of grants in the current cycle. Squash discards are not counted.
- R10: While reset is active and during the two synchronising cycles after it is released, slots are empty, release strobes are low and busy counters are zero.
- R11: Slots fill from index 0 with no gaps. Completions go first, in ascending class order. Single-cycle grants follow, oldest first. Slots left unused are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| head_vld | input | NCLS | Class head valid |
| head_seq | input | NCLS x SEQ_W | Class head sequence number |
| head_sqsh | input | NCLS | Class head squashed |
| fu_avail | input | NCLS | Class functional unit free this cycle |
| head_pop | output | NCLS | Remove head from class queue (grant or discard) |
| fu_claim | output | NCLS | Class functional unit taken this cycle |
| fu_release | output | NCLS | Class functional unit returned |
| iss_cnt | output | CW | Grants this cycle |
| slot_vld | output | W | Issue slot valid |
| slot_seq | output | W x SEQ_W | Issue slot sequence number |
| slot_cls | output | W x CLS_W | Issue slot class index |
| busy_cnt | output | NCLS x CNT_W | Per-class busy event counter |

## Verification
The interesting collision is a multi-cycle completion being delivered in the same cycle as fresh heads compete to issue. The delivered result consumes a slot, so fewer new grants fit, and it also decides which slot index each single-cycle grant lands in. The bench provokes this with directed vectors that start class 2 and class 3 operations and then offer several old heads while their countdowns expire, and it keeps doing so under long random traffic. A behavioural model decides every cycle which completions are delivered and which heads are walked in age order. It then judges the pops, claims, count, slot contents, releases and busy counters against the design.

// File: rtl/iss_sel_pkg.sv
package iss_sel_pkg;

  // Age order: smaller sequence first, lower class index on a tie.
  function automatic logic is_older(input logic [31:0] seq_a, input int idx_a,
                                    input logic [31:0] seq_b, input int idx_b);
    return (seq_a < seq_b) || ((seq_a == seq_b) && (idx_a < idx_b));
  endfunction

endpackage

// File: rtl/iss_rst_sync.sv
module iss_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/iss_age_rank.sv
module iss_age_rank #(
  parameter int NCLS  = 4,
  parameter int SEQ_W = 8,
  parameter int CW    = 3
) (
  input  logic [NCLS-1:0]            member,
  input  logic [NCLS-1:0][SEQ_W-1:0] seq,
  output logic [NCLS-1:0][CW-1:0]    older_cnt
);
  import iss_sel_pkg::*;

  localparam logic [CW-1:0] ONE_C = CW'(1);

  // For each lane: how many member lanes are strictly older.
  always_comb begin
    older_cnt = '0;
    for (int c = 0; c < NCLS; c++) begin
      for (int j = 0; j < NCLS; j++) begin
        if (j != c && member[j] &&
            is_older(32'(seq[j]), j, 32'(seq[c]), c)) begin
          older_cnt[c] = older_cnt[c] + ONE_C;
        end
      end
    end
  end
endmodule

// File: rtl/iss_cmpl_trk.sv
module iss_cmpl_trk #(
  parameter int                      NCLS    = 4,
  parameter int                      SEQ_W   = 8,
  parameter int                      LAT_W   = 4,
  parameter logic [NCLS*LAT_W-1:0]   ISS_LAT = 16'h1311
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCLS-1:0]            start,
  input  logic [NCLS-1:0][SEQ_W-1:0] start_seq,
  input  logic [NCLS-1:0]            deliver,
  output logic [NCLS-1:0]            pend,
  output logic [NCLS-1:0]            ready,
  output logic [NCLS-1:0][SEQ_W-1:0] pend_seq
);
  localparam logic [LAT_W-1:0] ONE_L = LAT_W'(1);

  logic [NCLS-1:0][LAT_W-1:0] tmr_q, tmr_d;
  logic [NCLS-1:0][SEQ_W-1:0] seq_q;

  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      pend[c]  = (tmr_q[c] != '0);
      ready[c] = (tmr_q[c] == ONE_L);
      if (start[c])
        tmr_d[c] = ISS_LAT[c*LAT_W +: LAT_W];
      else if (tmr_q[c] > ONE_L)
        tmr_d[c] = tmr_q[c] - ONE_L;
      else if (ready[c] && deliver[c])
        tmr_d[c] = '0;
      else
        tmr_d[c] = tmr_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      seq_q <= '0;
    end else begin
      tmr_q <= tmr_d;
      for (int c = 0; c < NCLS; c++) begin
        if (start[c]) seq_q[c] <= start_seq[c];
      end
    end
  end

  assign pend_seq = seq_q;
endmodule

// File: rtl/iss_busy_ctr.sv
module iss_busy_ctr #(
  parameter int NCLS  = 4,
  parameter int CNT_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCLS-1:0]            inc,
  output logic [NCLS-1:0][CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE_K = CNT_W'(1);

  logic [NCLS-1:0][CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    for (int c = 0; c < NCLS; c++) cnt_d[c] = cnt_q[c] + ONE_K;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else begin
      for (int c = 0; c < NCLS; c++) begin
        if (inc[c]) cnt_q[c] <= cnt_d[c];
      end
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/iss_oldest_sel.sv
module iss_oldest_sel #(
  parameter int                    NCLS     = 4,
  parameter int                    W        = 2,
  parameter int                    SEQ_W    = 8,
  parameter int                    CNT_W    = 8,
  parameter int                    LAT_W    = 4,
  parameter logic [NCLS-1:0]       NEEDS_FU = 4'b1101,
  parameter logic [NCLS-1:0]       MULTI    = 4'b1100,
  parameter logic [NCLS*LAT_W-1:0] ISS_LAT  = 16'h1311,
  localparam int                   CLS_W    = (NCLS > 1) ? $clog2(NCLS) : 1,
  localparam int                   CW       = $clog2(((NCLS > W) ? NCLS : W) + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCLS-1:0]            head_vld,
  input  logic [NCLS-1:0][SEQ_W-1:0] head_seq,
  input  logic [NCLS-1:0]            head_sqsh,
  input  logic [NCLS-1:0]            fu_avail,
  output logic [NCLS-1:0]            head_pop,
  output logic [NCLS-1:0]            fu_claim,
  output logic [NCLS-1:0]            fu_release,
  output logic [CW-1:0]              iss_cnt,
  output logic [W-1:0]               slot_vld,
  output logic [W-1:0][SEQ_W-1:0]    slot_seq,
  output logic [W-1:0][CLS_W-1:0]    slot_cls,
  output logic [NCLS-1:0][CNT_W-1:0] busy_cnt
);
  localparam logic [CW-1:0] W_L   = CW'(W);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic rst_sync_n;

  logic [NCLS-1:0]          pend, ready, deliver;
  logic [NCLS-1:0][SEQ_W-1:0] pend_seq;
  logic [NCLS-1:0]          cand, elig, blocked, grant, sgl_grant, busy_ev, lat1;
  logic [NCLS-1:0][CW-1:0]  older_elig, older_sgl, cmpl_slot;
  logic [CW-1:0]            ncmpl, budget, grant_cnt;

  logic [W-1:0]             slot_v_d, slot_v_q;
  logic [W-1:0][SEQ_W-1:0]  slot_s_d, slot_s_q;
  logic [W-1:0][CLS_W-1:0]  slot_c_d, slot_c_q;
  logic [NCLS-1:0]          rel_d, rel_q;

  iss_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  // Per-class static attribute: pipelined (delay of one) completion.
  for (genvar g = 0; g < NCLS; g++) begin : g_lat
    assign lat1[g] = (ISS_LAT[g*LAT_W +: LAT_W] == LAT_W'(1));
  end

  // Candidate classification.
  always_comb begin
    cand    = head_vld & ~head_sqsh;
    elig    = cand & ~pend & (fu_avail | ~NEEDS_FU);
    blocked = cand & ~elig;
  end

  // Completions claim slots first, lowest class index first.
  always_comb begin
    ncmpl     = '0;
    deliver   = '0;
    cmpl_slot = '0;
    for (int c = 0; c < NCLS; c++) begin
      if (ready[c] && (ncmpl < W_L)) begin
        deliver[c]   = 1'b1;
        cmpl_slot[c] = ncmpl;
        ncmpl        = ncmpl + ONE_C;
      end
    end
    budget = W_L - ncmpl;
  end

  iss_age_rank #(.NCLS(NCLS), .SEQ_W(SEQ_W), .CW(CW)) u_rank_elig (
    .member(elig), .seq(head_seq), .older_cnt(older_elig)
  );

  // Grant walk: a lane is reached when fewer older eligible lanes exist
  // than the remaining budget.
  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      grant[c]   = elig[c]    && (older_elig[c] < budget);
      busy_ev[c] = blocked[c] && (older_elig[c] < budget);
    end
    sgl_grant = grant & ~MULTI;
  end

  iss_age_rank #(.NCLS(NCLS), .SEQ_W(SEQ_W), .CW(CW)) u_rank_sgl (
    .member(sgl_grant), .seq(head_seq), .older_cnt(older_sgl)
  );

  // Slot packing: completions at the bottom, single-cycle grants above.
  always_comb begin
    slot_v_d = '0;
    slot_s_d = '0;
    slot_c_d = '0;
    for (int c = 0; c < NCLS; c++) begin
      for (int s = 0; s < W; s++) begin
        if (deliver[c] && (cmpl_slot[c] == CW'(s))) begin
          slot_v_d[s] = 1'b1;
          slot_s_d[s] = pend_seq[c];
          slot_c_d[s] = CLS_W'(c);
        end
        if (sgl_grant[c] && ((ncmpl + older_sgl[c]) == CW'(s))) begin
          slot_v_d[s] = 1'b1;
          slot_s_d[s] = head_seq[c];
          slot_c_d[s] = CLS_W'(c);
        end
      end
    end
  end

  always_comb begin
    grant_cnt = '0;
    for (int c = 0; c < NCLS; c++) begin
      if (grant[c]) grant_cnt = grant_cnt + ONE_C;
    end
  end

  // Unit return: after a grant for single-cycle or pipelined classes,
  // after delivery for classes that hold their unit.
  always_comb begin
    rel_d = NEEDS_FU & ((grant & (~MULTI | lat1)) | (deliver & MULTI & ~lat1));
  end

  iss_cmpl_trk #(.NCLS(NCLS), .SEQ_W(SEQ_W), .LAT_W(LAT_W), .ISS_LAT(ISS_LAT)) u_trk (
    .clk(clk), .rst_n(rst_sync_n), .start(grant & MULTI), .start_seq(head_seq),
    .deliver(deliver), .pend(pend), .ready(ready), .pend_seq(pend_seq)
  );

  iss_busy_ctr #(.NCLS(NCLS), .CNT_W(CNT_W)) u_busy (
    .clk(clk), .rst_n(rst_sync_n), .inc(busy_ev), .cnt(busy_cnt)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      slot_v_q <= '0;
      slot_s_q <= '0;
      slot_c_q <= '0;
      rel_q    <= '0;
    end else begin
      slot_v_q <= slot_v_d;
      rel_q    <= rel_d;
      for (int s = 0; s < W; s++) begin
        if (slot_v_d[s]) begin
          slot_s_q[s] <= slot_s_d[s];
          slot_c_q[s] <= slot_c_d[s];
        end
      end
    end
  end

  assign head_pop   = (head_vld & head_sqsh) | grant;
  assign fu_claim   = grant & NEEDS_FU;
  assign fu_release = rel_q;
  assign iss_cnt    = grant_cnt;
  assign slot_vld   = slot_v_q;
  assign slot_seq   = slot_s_q;
  assign slot_cls   = slot_c_q;
endmodule

// File: rtl/iss_oldest_sel_chk.sv
module iss_oldest_sel_chk #(
  parameter int                    NCLS     = 4,
  parameter int                    W        = 2,
  parameter int                    CNT_W    = 8,
  parameter int                    CW       = 3,
  parameter logic [NCLS-1:0]       NEEDS_FU = 4'b1101,
  parameter logic [NCLS-1:0]       MULTI    = 4'b1100
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NCLS-1:0]            head_vld,
  input logic [NCLS-1:0]            head_sqsh,
  input logic [NCLS-1:0]            fu_avail,
  input logic [NCLS-1:0]            head_pop,
  input logic [NCLS-1:0]            fu_claim,
  input logic [NCLS-1:0]            fu_release,
  input logic [CW-1:0]              iss_cnt,
  input logic [W-1:0]               slot_vld,
  input logic [NCLS-1:0][CNT_W-1:0] busy_cnt
);
  p_issue_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_cnt <= CW'(W));

  p_cnt_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(iss_cnt) == $countones(head_pop & ~(head_vld & head_sqsh)));

  p_slots_packed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_vld + W'(1)) & slot_vld) == '0);

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    p_squash_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (head_vld[c] && head_sqsh[c]) |-> (head_pop[c] && !fu_claim[c]));

    p_claim_avail_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fu_claim[c] |-> (fu_avail[c] && head_pop[c]));

    p_busy_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_cnt[c] == $past(busy_cnt[c])) ||
      (busy_cnt[c] == $past(busy_cnt[c]) + CNT_W'(1)));

    if (NEEDS_FU[c] && !MULTI[c]) begin : g_sgl
      p_single_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fu_claim[c] |=> fu_release[c]);
    end
  end
endmodule

bind iss_oldest_sel iss_oldest_sel_chk #(
  .NCLS(NCLS), .W(W), .CNT_W(CNT_W), .CW(CW), .NEEDS_FU(NEEDS_FU), .MULTI(MULTI)
) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .head_vld(head_vld), .head_sqsh(head_sqsh),
  .fu_avail(fu_avail), .head_pop(head_pop), .fu_claim(fu_claim),
  .fu_release(fu_release), .iss_cnt(iss_cnt), .slot_vld(slot_vld),
  .busy_cnt(busy_cnt)
);

// File: tb/iss_oldest_sel_tb.sv
`timescale 1ns/1ps
module iss_oldest_sel_tb_top;
  localparam int NC = 4;
  localparam int WD = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [NC-1:0]       vld, sqsh, avail;
  logic [NC-1:0][7:0]  seq;
  logic [NC-1:0]       pop, claim, rel;
  logic [2:0]          cnt;
  logic [WD-1:0]       sv;
  logic [WD-1:0][7:0]  ss;
  logic [WD-1:0][1:0]  sc;
  logic [NC-1:0][7:0]  busy;

  always #2.5 clk = ~clk;

  iss_oldest_sel dut_i (
    .clk(clk), .rst_n(rst_n), .head_vld(vld), .head_seq(seq), .head_sqsh(sqsh),
    .fu_avail(avail), .head_pop(pop), .fu_claim(claim), .fu_release(rel),
    .iss_cnt(cnt), .slot_vld(sv), .slot_seq(ss), .slot_cls(sc), .busy_cnt(busy)
  );

  // Class attributes per the requirements.
  int needs [NC] = '{1, 0, 1, 1};
  int multi [NC] = '{0, 0, 1, 1};
  int dly   [NC] = '{1, 1, 3, 1};

  // Reference state.
  int m_tmr[NC], m_pseq[NC], m_busy[NC];
  int m_rel[NC];
  int m_sv[WD], m_ss[WD], m_sc[WD];
  // Next-state staging.
  int n_tmr[NC], n_pseq[NC], n_busy[NC], n_rel[NC];
  int n_sv[WD], n_ss[WD], n_sc[WD];

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NC; c++) begin
      m_tmr[c] = 0; m_pseq[c] = 0; m_busy[c] = 0; m_rel[c] = 0;
    end
    for (int s = 0; s < WD; s++) begin
      m_sv[s] = 0; m_ss[s] = 0; m_sc[s] = 0;
    end
  endtask

  // Compare this cycle and compute the next reference state.
  task automatic step();
    int ord[NC];
    int n, used, ncmpl, sg, budget, tmp, el;
    int grant[NC], dlv[NC];
    int e_pop, e_claim;

    // Registered outputs against the current reference state.
    for (int s = 0; s < WD; s++) begin
      chk("R11 slot valid", int'(sv[s]), m_sv[s]);
      if (m_sv[s] != 0) begin
        chk("R6 R7 slot seq", int'(ss[s]), m_ss[s]);
        chk("R6 R7 slot class", int'(sc[s]), m_sc[s]);
      end
    end
    for (int c = 0; c < NC; c++) begin
      chk("R7 release", int'(rel[c]), m_rel[c]);
      chk("R4 R8 busy count", int'(busy[c]), m_busy[c]);
    end

    for (int s = 0; s < WD; s++) begin n_sv[s] = 0; n_ss[s] = m_ss[s]; n_sc[s] = m_sc[s]; end
    for (int c = 0; c < NC; c++) begin grant[c] = 0; dlv[c] = 0; end

    ncmpl = 0;
    for (int c = 0; c < NC; c++) begin
      if (m_tmr[c] == 1 && ncmpl < WD) begin
        dlv[c] = 1;
        n_sv[ncmpl] = 1; n_ss[ncmpl] = m_pseq[c]; n_sc[ncmpl] = c;
        ncmpl++;
      end
    end
    budget = WD - ncmpl;

    n = 0;
    for (int c = 0; c < NC; c++)
      if (vld[c] && !sqsh[c]) begin ord[n] = c; n++; end
    for (int i = 0; i < n; i++)
      for (int j = 0; j + 1 < n - i; j++)
        if (seq[ord[j]] > seq[ord[j+1]] ||
            (seq[ord[j]] == seq[ord[j+1]] && ord[j] > ord[j+1])) begin
          tmp = ord[j]; ord[j] = ord[j+1]; ord[j+1] = tmp;
        end

    for (int c = 0; c < NC; c++) n_busy[c] = m_busy[c];
    used = 0; sg = 0;
    for (int k = 0; k < n; k++) begin
      int c;
      c = ord[k];
      if (used >= budget) break;
      el = (m_tmr[c] == 0) && (avail[c] || needs[c] == 0);
      if (el) begin
        grant[c] = 1;
        used++;
        if (multi[c] == 0) begin
          n_sv[ncmpl + sg] = 1; n_ss[ncmpl + sg] = seq[c]; n_sc[ncmpl + sg] = c;
          sg++;
        end
      end else begin
        n_busy[c] = (m_busy[c] + 1) & 255;
      end
    end

    for (int c = 0; c < NC; c++) begin
      e_pop   = ((vld[c] && sqsh[c]) || grant[c] != 0) ? 1 : 0;
      e_claim = (grant[c] != 0 && needs[c] != 0) ? 1 : 0;
      chk("R1 R3 pop", int'(pop[c]), e_pop);
      chk("R4 R5 claim", int'(claim[c]), e_claim);
      n_rel[c] = (needs[c] != 0 &&
                  ((grant[c] != 0 && (multi[c] == 0 || dly[c] == 1)) ||
                   (dlv[c] != 0 && multi[c] != 0 && dly[c] > 1))) ? 1 : 0;
      n_pseq[c] = m_pseq[c];
      if (grant[c] != 0 && multi[c] != 0) begin
        n_tmr[c] = dly[c]; n_pseq[c] = seq[c];
      end else if (m_tmr[c] > 1) n_tmr[c] = m_tmr[c] - 1;
      else if (m_tmr[c] == 1 && dlv[c] != 0) n_tmr[c] = 0;
      else n_tmr[c] = m_tmr[c];
    end
    chk("R2 R9 issue count", int'(cnt), used);
  endtask

  task automatic commit();
    for (int c = 0; c < NC; c++) begin
      m_tmr[c] = n_tmr[c]; m_pseq[c] = n_pseq[c]; m_busy[c] = n_busy[c]; m_rel[c] = n_rel[c];
    end
    for (int s = 0; s < WD; s++) begin
      m_sv[s] = n_sv[s]; m_ss[s] = n_ss[s]; m_sc[s] = n_sc[s];
    end
  endtask

  task automatic cycle(input logic [3:0] v, input logic [3:0] q, input logic [3:0] a,
                       input int s0, input int s1, input int s2, input int s3);
    @(negedge clk);
    vld = v; sqsh = q; avail = a;
    seq[0] = 8'(s0); seq[1] = 8'(s1); seq[2] = 8'(s2); seq[3] = 8'(s3);
    #1;
    step();
    @(posedge clk);
    commit();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    vld = '0; sqsh = '0; avail = '0; seq = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: state under reset.
    chk("R10 reset slots", int'(sv), 0);
    chk("R10 reset release", int'(rel), 0);
    for (int c = 0; c < NC; c++) chk("R10 reset busy", int'(busy[c]), 0);
    rst_n = 1'b1;
    // Idle cycles while the reset release synchronises.
    repeat (3) cycle(4'h0, 4'h0, 4'h0, 0, 0, 0, 0);

    // R1: oldest two eligible win (class 1 seq 10, class 3 seq 20).
    cycle(4'hF, 4'h0, 4'hF, 40, 10, 30, 20);
    // R1: tie on sequence, lower class index first.
    cycle(4'h3, 4'h0, 4'hF, 7, 7, 0, 0);
    // R3: squashed oldest heads are discarded without using budget.
    cycle(4'hF, 4'h5, 4'hF, 1, 9, 2, 8);
    // R4: oldest class unit busy, skipped; R5: class 1 ignores availability.
    cycle(4'h7, 4'h0, 4'h0, 3, 50, 60, 0);
    // R7 + R2: start class 2 (delay 3), then offer old heads as it completes.
    cycle(4'h4, 4'h0, 4'hF, 0, 0, 5, 0);
    cycle(4'h4, 4'h0, 4'hF, 0, 0, 6, 0);      // R8: pending class 2 blocked
    cycle(4'hB, 4'h0, 4'hF, 11, 12, 0, 13);
    cycle(4'hB, 4'h0, 4'hF, 21, 22, 0, 23);   // completion takes a slot
    cycle(4'h0, 4'h0, 4'h0, 0, 0, 0, 0);
    cycle(4'h0, 4'h0, 4'h0, 0, 0, 0, 0);

    // Mixed random traffic.
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] rv, rq, ra;
      for (int c = 0; c < NC; c++) begin
        rv[c] = ($urandom_range(0, 9) < 7);
        rq[c] = ($urandom_range(0, 9) < 2);
        ra[c] = ($urandom_range(0, 9) < 7);
      end
      cycle(rv, rq, ra, $urandom_range(0, 255), $urandom_range(0, 255),
            $urandom_range(0, 255), $urandom_range(0, 255));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule